// File: doc/BRIEF.md
# Power-Good Strap Sampler and Mode Decoder

This block takes the board straps that set up a clock generator at power-on and decodes them once. An active-low, level-sensitive power-good strobe marks when the straps are valid. After the strobe has stayed low for a programmable settling window, the block takes one snapshot of three inputs: the three-level mode strap, the two frequency-select straps and the drive-swing strap. It then locks and ignores the strobe and the straps until the next reset. The settling window lets any glitch on the supply die out before the straps are read.

The mode strap arrives already resolved into a two-bit level code: 00 is low, 01 is mid, 10 is high, and 11 is an illegal reading. From the snapshot the block derives four things. The first is the operating mode: tri-state, normal, test or reserved. The second is the CPU frequency code. The third is the choice between the external 66 MHz input and the internal 66 MHz source. The fourth is the set of test-clock divide ratios. It also outputs the drive-current multiplier choice and a three-bit readback of the latched straps for the register file.

Until the snapshot is taken, `mode_valid` stays low and every decoded output holds its parked value, so downstream clock stages stay quiet.

Top module: `pg_strap_decoder`

## Requirements
- R1: While reset is held and after it is released, before any capture, the outputs are mode_valid=0, op_mode=00, cpu_freq=00, ext66_sel=0, cur_mult6=0, tdiv_log2=0 and strap_rb=000.
- R2: Count as edge 1 the first rising clock edge at which pg_n is low. If pg_n then stays low, mode_valid is still 0 after edge SETTLE_CYC+3 and is 1 after edge SETTLE_CYC+4.
- R3: If pg_n returns high before the capture, the sequence aborts and mode_valid stays 0. A later low level on pg_n restarts the full settling window from the beginning.
- R4: The straps are sampled at the edge where mode_valid rises. Any later change on s2_code, fsel or swing_strap has no effect on any output.
- R5: Once mode_valid is 1, it stays 1 and the outputs stay unchanged whatever pg_n does, until reset.
- R6: When the latched s2_code is 00 (low) or 10 (high), op_mode is 01 (normal) and cpu_freq equals the latched fsel. The fsel codes are 00 for 66 MHz, 01 for 100 MHz, 10 for 200 MHz and 11 for 133 MHz.
- R7: ext66_sel is 1 exactly when op_mode is normal and the latched s2_code is 10. In that case the 66 MHz group follows the external input and PCI runs at half of it.
- R8: When the latched s2_code is 01 (mid) and fsel is 00, op_mode is 00 (tri-state), cpu_freq is 00 and tdiv_log2 is 0.
- R9: When the latched s2_code is 01 and fsel is 01, op_mode is 10 (test) and cpu_freq is 10. tdiv_log2 holds the log2 test-clock divisor of each output group in 2-bit fields: [1:0] CPU=1, [3:2] 66 MHz group=2, [5:4] PCI=3, [7:6] USB/DOT=1, [9:8] REF=0. The whole field therefore reads 0x079.
- R10: When the latched s2_code is 01 with fsel 10 or 11, or the latched s2_code is 11, op_mode is 11 (reserved), cpu_freq is 00, ext66_sel is 0 and tdiv_log2 is 0.
- R11: cur_mult6 equals the latched swing strap: 0 selects the 4x current multiplier and 1 selects 6x.
- R12: strap_rb reads bit 2 = 1 only if the latched s2_code is 10, and bits 1:0 = the latched fsel. A mid reading of the mode strap therefore shows bit 2 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_n | input | 1 | Active-low power-good strobe, asynchronous |
| s2_code | input | 2 | Resolved level of the three-level mode strap |
| fsel | input | 2 | Frequency-select straps |
| swing_strap | input | 1 | Drive-swing strap |
| mode_valid | output | 1 | High once the straps are latched |
| op_mode | output | 2 | 00 tri-state, 01 normal, 10 test, 11 reserved |
| cpu_freq | output | 2 | CPU frequency code |
| ext66_sel | output | 1 | 66 MHz group follows the external input |
| cur_mult6 | output | 1 | Selects the 6x current multiplier |
| tdiv_log2 | output | 10 | Test-mode divide ratios (log2), one field per group |
| strap_rb | output | 3 | Latched strap readback |

## Verification
A sequencer that leaves its waiting state one cycle early or late shows up at once: mode_valid rises on the wrong edge relative to pg_n. Likewise, a counter that fails to clear on an aborted strobe gives a shortened window on the second attempt. A capture register that keeps loading after lock shows on the very next edge after a strap change, as a change in strap_rb, cpu_freq or op_mode. Decode faults are static once the straps are locked, so each strap pattern is checked a few cycles after lock.

// File: rtl/pgs_pkg.sv
// Package: shared encodings for the strap sampler.
// Assumes: the three-level strap is resolved outside into s2_lvl_e codes.
package pgs_pkg;

    typedef enum logic [1:0] {
        S2_LO  = 2'b00,
        S2_MID = 2'b01,
        S2_HI  = 2'b10,
        S2_BAD = 2'b11
    } s2_lvl_e;

    typedef enum logic [1:0] {
        OPM_TRI  = 2'b00,
        OPM_NORM = 2'b01,
        OPM_TEST = 2'b10,
        OPM_RSVD = 2'b11
    } opmode_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'b00,
        SQ_WAIT   = 2'b01,
        SQ_SAMPLE = 2'b10,
        SQ_LOCKED = 2'b11
    } seq_e;

    typedef struct packed {
        logic [1:0] s2;
        logic [1:0] fsel;
        logic       swing;
    } strap_t;

    // log2 of the test-clock divisor for each output group
    localparam logic [1:0] TDIV_CPU = 2'd1;
    localparam logic [1:0] TDIV_G66 = 2'd2;
    localparam logic [1:0] TDIV_PCI = 2'd3;
    localparam logic [1:0] TDIV_USB = 2'd1;
    localparam logic [1:0] TDIV_REF = 2'd0;

    // frequency code used by test mode (shares the fastest divider set)
    localparam logic [1:0] FSEL_TEST = 2'b10;

endpackage

// File: rtl/pgs_sync.sv
// Module: pgs_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes: the input is a slow level; reset value is parameterised.
module pgs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the level through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pgs_seq.sv
// Module: pgs_seq
// Qualification sequencer: waits for the synchronised strobe to stay low for
// SETTLE_CYC cycles, issues a one-cycle capture, then locks for good.
// Assumes: pg_low is already synchronous; SETTLE_CYC >= 1.
module pgs_seq
    import pgs_pkg::*;
#(
    parameter int SETTLE_CYC = 3580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_low,
    output logic cap_en,
    output logic locked
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    seq_e          state, state_nx;
    logic [CW-1:0] cnt;

    // next-state logic of the qualification sequence
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:   if (pg_low) state_nx = SQ_WAIT;
            SQ_WAIT: begin
                if (!pg_low)              state_nx = SQ_IDLE;
                else if (cnt == CNT_LAST) state_nx = SQ_SAMPLE;
            end
            SQ_SAMPLE: state_nx = SQ_LOCKED;
            SQ_LOCKED: state_nx = SQ_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // settling counter, cleared whenever the sequence is not waiting
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt <= '0;
        else if (state == SQ_WAIT && state_nx == SQ_WAIT) cnt <= cnt + 1'b1;
        else                                         cnt <= '0;
    end

    assign cap_en = (state == SQ_SAMPLE);
    assign locked = (state == SQ_LOCKED);

    // R2: the counter never runs past the window
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT) |-> (cnt <= CNT_LAST));

    // R2: lock is entered only through the capture cycle
    a_r2_lock_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cap_en));

    // R3: strobe released while waiting aborts to idle
    a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT && !pg_low) |=> (state == SQ_IDLE));

    // R5: once locked, stays locked
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

// File: rtl/pgs_capture.sv
// Module: pgs_capture
// Holds the strap snapshot. Loads only on the single capture pulse.
// Assumes: cap_en occurs at most once between resets.
module pgs_capture
    import pgs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cap_en,
    input  logic   locked,
    input  strap_t strap_in,
    output strap_t strap_q
);
    // load the snapshot on the capture pulse
    always_ff @(posedge clk) begin
        if (!rst_n)      strap_q <= '0;
        else if (cap_en) strap_q <= strap_in;
    end

    // R4: the snapshot never moves once locked
    a_r4_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(strap_q));

endmodule

// File: rtl/pgs_decode.sv
// Module: pgs_decode
// Combinational decode of the strap snapshot into mode controls.
// Assumes: outputs are parked (tri-state, zero) while locked is low.
module pgs_decode
    import pgs_pkg::*;
(
    input  logic       locked,
    input  strap_t     strap_q,
    output opmode_e    op_mode,
    output logic [1:0] cpu_freq,
    output logic       ext66_sel,
    output logic       cur_mult6,
    output logic [9:0] tdiv_log2,
    output logic [2:0] strap_rb
);
    s2_lvl_e lvl;
    assign lvl = s2_lvl_e'(strap_q.s2);

    // mode, frequency and divider decode
    always_comb begin
        op_mode   = OPM_TRI;
        cpu_freq  = 2'b00;
        ext66_sel = 1'b0;
        tdiv_log2 = '0;
        if (locked) begin
            unique case (lvl)
                S2_LO, S2_HI: begin
                    op_mode   = OPM_NORM;
                    cpu_freq  = strap_q.fsel;
                    ext66_sel = (lvl == S2_HI);
                end
                S2_MID: begin
                    unique case (strap_q.fsel)
                        2'b00:   op_mode = OPM_TRI;
                        2'b01: begin
                            op_mode   = OPM_TEST;
                            cpu_freq  = FSEL_TEST;
                            tdiv_log2 = {TDIV_REF, TDIV_USB, TDIV_PCI, TDIV_G66, TDIV_CPU};
                        end
                        default: op_mode = OPM_RSVD;
                    endcase
                end
                S2_BAD: op_mode = OPM_RSVD;
            endcase
        end
    end

    // readback and swing select
    always_comb begin
        cur_mult6 = locked & strap_q.swing;
        strap_rb  = locked ? {lvl == S2_HI, strap_q.fsel} : 3'b000;
    end

    // R7: external source selected only in normal mode
    always_comb begin
        if (ext66_sel)
            a_r7_ext_normal_only: assert (op_mode == OPM_NORM);
    end

endmodule

// File: rtl/pg_strap_decoder.sv
// Module: pg_strap_decoder (top)
// Samples the board straps once after a qualified power-good strobe and
// decodes them into clock-generator mode controls.
// Assumes: pg_n and straps are asynchronous slow levels; the three-level
// strap is already resolved into a 2-bit code.
module pg_strap_decoder
    import pgs_pkg::*;
#(
    parameter int SETTLE_CYC  = 3580,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_n,
    input  logic [1:0] s2_code,
    input  logic [1:0] fsel,
    input  logic       swing_strap,
    output logic       mode_valid,
    output logic [1:0] op_mode,
    output logic [1:0] cpu_freq,
    output logic       ext66_sel,
    output logic       cur_mult6,
    output logic [9:0] tdiv_log2,
    output logic [2:0] strap_rb
);
    logic    pg_n_s;
    logic    cap_en;
    logic    locked;
    strap_t  strap_in;
    strap_t  strap_q;
    opmode_e mode_e;

    assign strap_in = '{s2: s2_code, fsel: fsel, swing: swing_strap};

    pgs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pg_n),
        .q     (pg_n_s)
    );

    pgs_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_low (!pg_n_s),
        .cap_en (cap_en),
        .locked (locked)
    );

    pgs_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .locked   (locked),
        .strap_in (strap_in),
        .strap_q  (strap_q)
    );

    pgs_decode u_dec (
        .locked    (locked),
        .strap_q   (strap_q),
        .op_mode   (mode_e),
        .cpu_freq  (cpu_freq),
        .ext66_sel (ext66_sel),
        .cur_mult6 (cur_mult6),
        .tdiv_log2 (tdiv_log2),
        .strap_rb  (strap_rb)
    );

    assign mode_valid = locked;
    assign op_mode    = mode_e;

    // R1: parked outputs until the straps are valid
    a_r1_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (op_mode == 2'b00 && tdiv_log2 == '0 && strap_rb == 3'b000));

    // R9: test dividers appear only in test mode
    a_r9_tdiv_test_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tdiv_log2 != '0) |-> (op_mode == 2'b10 && cpu_freq == 2'b10));

    // R5: outputs hold once valid
    a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |=> ($stable(op_mode) && $stable(cpu_freq) && $stable(strap_rb)));

endmodule

// File: tb/pg_strap_decoder_tb.sv
module pg_strap_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg_n = 1'b1;
    logic [1:0] s2_code = 2'b00;
    logic [1:0] fsel = 2'b00;
    logic       swing_strap = 1'b0;
    logic       mode_valid, ext66_sel, cur_mult6;
    logic [1:0] op_mode, cpu_freq;
    logic [9:0] tdiv_log2;
    logic [2:0] strap_rb;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_strap_decoder #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .s2_code(s2_code), .fsel(fsel),
        .swing_strap(swing_strap), .mode_valid(mode_valid), .op_mode(op_mode),
        .cpu_freq(cpu_freq), .ext66_sel(ext66_sel), .cur_mult6(cur_mult6),
        .tdiv_log2(tdiv_log2), .strap_rb(strap_rb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pg_n = 1'b1;
        edges(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // reset, set straps, drop the strobe and wait until lock (checks R2 timing)
    task automatic lock_up(input logic [1:0] s2, input logic [1:0] fs, input logic sw);
        do_reset();
        s2_code = s2; fsel = fs; swing_strap = sw;
        pg_n = 1'b0;
        edges(SETTLE + 3);
        chk("R2 not yet valid", 32'(mode_valid), 32'd0);
        edges(1);
        chk("R2 valid on time", 32'(mode_valid), 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid in reset", 32'(mode_valid), 32'd0);
        do_reset();
        edges(4);
        chk("R1 outputs parked", {mode_valid, op_mode, cpu_freq, ext66_sel, cur_mult6, tdiv_log2, strap_rb}, 32'd0);
    endtask

    task automatic t_normal();
        for (int h = 0; h < 2; h++) begin
            for (int f = 0; f < 4; f++) begin
                lock_up(h ? 2'b10 : 2'b00, 2'(f), 1'b0);
                chk("R6 normal mode", 32'(op_mode), 32'd1);
                chk("R6 cpu_freq", 32'(cpu_freq), 32'(f));
                chk("R7 ext66_sel", 32'(ext66_sel), 32'(h));
                chk("R12 readback", 32'(strap_rb), 32'({h[0], 2'(f)}));
            end
        end
    endtask

    task automatic t_glitch();
        do_reset();
        s2_code = 2'b00; fsel = 2'b11; swing_strap = 1'b0;
        pg_n = 1'b0;
        edges(SETTLE / 2);
        pg_n = 1'b1;
        edges(SETTLE + 8);
        chk("R3 aborted stays invalid", 32'(mode_valid), 32'd0);
        pg_n = 1'b0;
        edges(SETTLE + 3);
        chk("R3 full window restarted", 32'(mode_valid), 32'd0);
        edges(1);
        chk("R3 lock after restart", 32'(mode_valid), 32'd1);
    endtask

    task automatic t_after_lock();
        lock_up(2'b10, 2'b01, 1'b1);
        s2_code = 2'b01; fsel = 2'b10; swing_strap = 1'b0;
        edges(3);
        chk("R4 straps ignored rb", 32'(strap_rb), 32'b101);
        chk("R4 straps ignored mode", {op_mode, cpu_freq, cur_mult6}, {2'b01, 2'b01, 1'b1});
        pg_n = 1'b1; edges(5); pg_n = 1'b0; edges(2); pg_n = 1'b1; edges(SETTLE + 6);
        chk("R5 strobe ignored valid", 32'(mode_valid), 32'd1);
        chk("R5 strobe ignored outputs", {op_mode, cpu_freq, strap_rb}, {2'b01, 2'b01, 3'b101});
    endtask

    task automatic t_mid();
        lock_up(2'b01, 2'b00, 1'b0);
        chk("R8 tristate", {op_mode, cpu_freq, ext66_sel, tdiv_log2}, 32'd0);
        chk("R12 mid reads low", 32'(strap_rb), 32'b000);
        lock_up(2'b01, 2'b01, 1'b0);
        chk("R9 test mode", 32'(op_mode), 32'd2);
        chk("R9 test cpu_freq", 32'(cpu_freq), 32'd2);
        chk("R9 test dividers", 32'(tdiv_log2), 32'h079);
        for (int f = 2; f < 4; f++) begin
            lock_up(2'b01, 2'(f), 1'b0);
            chk("R10 reserved mid", {op_mode, cpu_freq, ext66_sel, tdiv_log2}, {2'b11, 2'b00, 1'b0, 10'd0});
        end
        lock_up(2'b11, 2'b10, 1'b0);
        chk("R10 reserved bad code", {op_mode, cpu_freq, ext66_sel, tdiv_log2}, {2'b11, 2'b00, 1'b0, 10'd0});
    endtask

    task automatic t_swing();
        lock_up(2'b00, 2'b00, 1'b1);
        chk("R11 mult6 set", 32'(cur_mult6), 32'd1);
        lock_up(2'b00, 2'b00, 1'b0);
        chk("R11 mult4 set", 32'(cur_mult6), 32'd0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_glitch();
        t_after_lock();
        t_mid();
        t_swing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R2 act=timeout exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule